// File: doc/BRIEF.md
# Packet Local-Bus DMA Engine

This block moves packet bytes between an on-chip byte FIFO and an external buffer memory on a shared local bus. A command gives a start address, a byte length and a direction. In transmit direction the engine reads the packet from memory in bursts and pushes each byte into the FIFO, where the MAC picks it up. In receive direction it pops bytes from the FIFO and writes them into a ring buffer. The write pointer folds back from the ring's last address to its first.

Bursts are paced by the FIFO occupancy. Every burst asks for the memory bus with a request/grant handshake and gives the bus back when the burst ends, so a second DMA channel can work between bursts. During transmission the MAC may report a collision. The engine then flushes the FIFO and fetches the packet again from its saved start, with no host action, for up to fifteen collisions. The sixteenth collision ends the packet with an excessive-collision flag.

Top module: `ldma_engine`

## Requirements
- R1: After reset `busy`, `done`, `xcol_abort`, `mem_req`, `mem_rd`, `mem_wr`, `fifo_push`, `fifo_pop` and `fifo_flush` are all 0.
- R2: A transmit command (`cmd_rx`=0) reads bytes from addresses `cmd_addr`, `cmd_addr`+1, ... (modulo 2^AW) and pushes them into the FIFO in that order. Each pushed byte equals `mem_rdata` in the same cycle, and the total is `cmd_len` bytes.
- R3: A receive command (`cmd_rx`=1) pops `cmd_len` bytes and writes byte i to the i-th address of the sequence that starts at `cmd_addr` and steps by one. The address after `ring_end` is `ring_start`, and no write falls outside `ring_start`..`ring_end`.
- R4: A burst is requested only when the free FIFO space (transmit) or the FIFO fill level (receive) is at least min(BURST, bytes still to move). No burst has more than BURST consecutive transfer cycles.
- R5: `mem_rd`/`mem_wr` are asserted only while `mem_req` is high. The first transfer of a burst comes after a cycle with `mem_gnt` high. `mem_req` goes low after every burst.
- R6: A collision (`col_detect` high for one cycle while a transmit is busy) causes a one-cycle `fifo_flush` in the next cycle. The whole packet is then fetched again from its original start address.
- R7: The first 15 collisions on one packet each cause a retry. The 16th causes a one-cycle `xcol_abort` pulse and a `fifo_flush`, and the engine returns to idle without `done`.
- R8: A transmit ends with one `done` pulse only after all bytes are fetched and `mac_tx_done` is seen. A `mac_tx_done` that arrives earlier is ignored.
- R9: A receive ends with one `done` pulse after its last memory write.
- R10: A command presented while `busy` is high is ignored. The running packet continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a packet (accepted only when idle) |
| cmd_rx | input | 1 | Direction: 0 transmit, 1 receive |
| cmd_addr | input | AW | Packet start address |
| cmd_len | input | LW | Packet length in bytes |
| ring_start | input | AW | First address of the receive ring |
| ring_end | input | AW | Last address of the receive ring |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle completion pulse |
| xcol_abort | output | 1 | One-cycle excessive-collision pulse |
| col_detect | input | 1 | Collision report from the MAC |
| mac_tx_done | input | 1 | MAC finished sending the packet |
| fifo_free | input | LVW | Free FIFO entries |
| fifo_level | input | LVW | Filled FIFO entries |
| fifo_push | output | 1 | Push `fifo_wdata` into the FIFO |
| fifo_wdata | output | DW | Byte pushed into the FIFO |
| fifo_pop | output | 1 | Pop the head byte of the FIFO |
| fifo_rdata | input | DW | Head byte of the FIFO (show-ahead) |
| fifo_flush | output | 1 | Empty the FIFO |
| mem_req | output | 1 | Local bus request |
| mem_gnt | input | 1 | Local bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe; data returns in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DW | Memory read data |
| mem_wdata | output | DW | Memory write data |

## Verification
Transmit is swept over lengths 1 to 9 and grant delays 0 to 2. Lengths below, equal to and above the burst size separate the short final burst from full ones, and the grant delays separate request timing from transfer timing. Receive is swept over every start offset in an eight-entry ring with lengths up to ten. Runs that cross `ring_end` expose wrap errors, and runs longer than the ring expose an off-by-one in the fold point. Starved FIFO patterns (full transmit FIFO, receive level below a burst) show whether the threshold gates requests. Collision patterns land mid-fetch, after fetch, fifteen times and sixteen times, which separates a retry from an abort.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_REQ   = 3'd2,
      ST_XFER  = 3'd3,
      ST_TXEND = 3'd4,
      ST_FLUSH = 3'd5
   } ldma_state_e;

endpackage

// File: rtl/ldma_addr_gen.sv
module ldma_addr_gen #(
   parameter int AW        = 16,
   parameter int LW        = 12,
   parameter bit RING_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          reload,
   input  logic          step,
   input  logic          dir_rx,
   input  logic [AW-1:0] start_addr,
   input  logic [LW-1:0] length,
   input  logic [AW-1:0] ring_lo,
   input  logic [AW-1:0] ring_hi,
   output logic [AW-1:0] addr,
   output logic [LW-1:0] remaining,
   output logic          rem_zero
);

   logic [AW-1:0] base_q, addr_q, lo_q, hi_q, addr_nx;
   logic [LW-1:0] len_q, rem_q;
   logic          rx_q;

   generate
      if (RING_WRAP) begin : g_wrap
         always_comb begin
            if (rx_q && (addr_q == hi_q)) addr_nx = lo_q;
            else                          addr_nx = addr_q + 1'b1;
         end
      end else begin : g_linear
         logic unused_ring;
         assign unused_ring = rx_q ^ (^lo_q) ^ (^hi_q);
         assign addr_nx     = addr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         len_q  <= '0;
         rem_q  <= '0;
         rx_q   <= 1'b0;
      end else if (load) begin
         base_q <= start_addr;
         addr_q <= start_addr;
         lo_q   <= ring_lo;
         hi_q   <= ring_hi;
         len_q  <= length;
         rem_q  <= length;
         rx_q   <= dir_rx;
      end else if (reload) begin
         addr_q <= base_q;
         rem_q  <= len_q;
      end else if (step) begin
         addr_q <= addr_nx;
         rem_q  <= rem_q - 1'b1;
      end
   end

   assign addr      = addr_q;
   assign remaining = rem_q;
   assign rem_zero  = (rem_q == '0);

endmodule

// File: rtl/ldma_retry_ctr.sv
module ldma_retry_ctr #(
   parameter int MAX_RETRY = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic hit,
   output logic at_limit
);

   localparam int CW = $clog2(MAX_RETRY + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clear)                   cnt_q <= '0;
      else if (hit && (cnt_q != LIMIT)) cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == LIMIT);

endmodule

// File: rtl/ldma_burst_fsm.sv
module ldma_burst_fsm
   import ldma_pkg::*;
#(
   parameter int LW    = 12,
   parameter int LVW   = 5,
   parameter int BURST = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic           cmd_rx,
   input  logic [LVW-1:0] fifo_free,
   input  logic [LVW-1:0] fifo_level,
   input  logic           mem_gnt,
   input  logic           col_detect,
   input  logic           mac_tx_done,
   input  logic [LW-1:0]  remaining,
   input  logic           rem_zero,
   input  logic           at_limit,
   output logic           ag_load,
   output logic           ag_reload,
   output logic           ag_step,
   output logic           rt_clear,
   output logic           rt_hit,
   output logic           mem_req,
   output logic           beat,
   output logic           flush,
   output logic           busy,
   output logic           done,
   output logic           abort,
   output logic           rx_mode
);

   localparam int CW  = ((LW > LVW) ? LW : LVW) + 1;
   localparam int BCW = $clog2(BURST + 1);

   ldma_state_e    st_q, st_d;
   logic           rx_q;
   logic [BCW-1:0] beat_q;
   logic           done_q, abort_q;
   logic           set_done, set_abort, load_beats;
   logic [CW-1:0]  need, room;
   logic           col_evt;

   always_comb begin
      need    = (CW'(remaining) < CW'(BURST)) ? CW'(remaining) : CW'(BURST);
      room    = rx_q ? CW'(fifo_level) : CW'(fifo_free);
      col_evt = !rx_q && col_detect && (st_q != ST_IDLE);
      beat    = (st_q == ST_XFER) && !col_evt;
   end

   always_comb begin
      st_d       = st_q;
      ag_load    = 1'b0;
      rt_clear   = 1'b0;
      rt_hit     = 1'b0;
      set_done   = 1'b0;
      set_abort  = 1'b0;
      load_beats = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (cmd_valid) begin
               ag_load  = 1'b1;
               rt_clear = 1'b1;
               st_d     = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (rem_zero) begin
               if (rx_q) begin
                  set_done = 1'b1;
                  st_d     = ST_IDLE;
               end else begin
                  st_d = ST_TXEND;
               end
            end else if (room >= need) begin
               load_beats = 1'b1;
               st_d       = ST_REQ;
            end
         end
         ST_REQ: begin
            if (mem_gnt) st_d = ST_XFER;
         end
         ST_XFER: begin
            if (beat_q == BCW'(1)) st_d = ST_WAIT;
         end
         ST_TXEND: begin
            if (mac_tx_done) begin
               set_done = 1'b1;
               st_d     = ST_IDLE;
            end
         end
         ST_FLUSH: st_d = ST_WAIT;
         default:  st_d = ST_IDLE;
      endcase
      if (col_evt) begin
         set_done   = 1'b0;
         load_beats = 1'b0;
         if (at_limit) begin
            set_abort = 1'b1;
            st_d      = ST_IDLE;
         end else begin
            rt_hit = 1'b1;
            st_d   = ST_FLUSH;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         rx_q    <= 1'b0;
         beat_q  <= '0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         done_q  <= set_done;
         abort_q <= set_abort;
         if (ag_load)         rx_q   <= cmd_rx;
         if (load_beats)      beat_q <= BCW'(need);
         else if (beat)       beat_q <= beat_q - 1'b1;
      end
   end

   assign ag_reload = (st_q == ST_FLUSH);
   assign ag_step   = beat;
   assign mem_req   = (st_q == ST_REQ) || (st_q == ST_XFER);
   assign flush     = (st_q == ST_FLUSH) || abort_q;
   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;
   assign abort     = abort_q;
   assign rx_mode   = rx_q;

endmodule

// File: rtl/ldma_engine.sv
module ldma_engine #(
   parameter int AW         = 16,
   parameter int LW         = 12,
   parameter int DW         = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int BURST      = 8,
   parameter int MAX_RETRY  = 15,
   parameter bit RING_WRAP  = 1'b1,
   parameter int LVW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic           cmd_rx,
   input  logic [AW-1:0]  cmd_addr,
   input  logic [LW-1:0]  cmd_len,
   input  logic [AW-1:0]  ring_start,
   input  logic [AW-1:0]  ring_end,
   output logic           busy,
   output logic           done,
   output logic           xcol_abort,
   input  logic           col_detect,
   input  logic           mac_tx_done,
   input  logic [LVW-1:0] fifo_free,
   input  logic [LVW-1:0] fifo_level,
   output logic           fifo_push,
   output logic [DW-1:0]  fifo_wdata,
   output logic           fifo_pop,
   input  logic [DW-1:0]  fifo_rdata,
   output logic           fifo_flush,
   output logic           mem_req,
   input  logic           mem_gnt,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   output logic           mem_wr,
   input  logic [DW-1:0]  mem_rdata,
   output logic [DW-1:0]  mem_wdata
);

   if (BURST < 1 || BURST > FIFO_DEPTH) begin : g_bad_burst
      $error("ldma_engine: BURST must lie in 1..FIFO_DEPTH");
   end
   if (BURST >= (1 << LW)) begin : g_bad_len
      $error("ldma_engine: BURST must be below 2**LW");
   end
   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("ldma_engine: MAX_RETRY must be at least 1");
   end
   if (LVW < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvw
      $error("ldma_engine: LVW too narrow for FIFO_DEPTH");
   end

   logic          ag_load, ag_reload, ag_step, rt_clear, rt_hit;
   logic          at_limit, rem_zero, beat, rx_mode;
   logic [LW-1:0] remaining;

   ldma_addr_gen #(
      .AW(AW), .LW(LW), .RING_WRAP(RING_WRAP)
   ) u_addr (
      .clk(clk), .rst_n(rst_n),
      .load(ag_load), .reload(ag_reload), .step(ag_step),
      .dir_rx(cmd_rx), .start_addr(cmd_addr), .length(cmd_len),
      .ring_lo(ring_start), .ring_hi(ring_end),
      .addr(mem_addr), .remaining(remaining), .rem_zero(rem_zero)
   );

   ldma_retry_ctr #(
      .MAX_RETRY(MAX_RETRY)
   ) u_retry (
      .clk(clk), .rst_n(rst_n),
      .clear(rt_clear), .hit(rt_hit), .at_limit(at_limit)
   );

   ldma_burst_fsm #(
      .LW(LW), .LVW(LVW), .BURST(BURST)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_rx(cmd_rx),
      .fifo_free(fifo_free), .fifo_level(fifo_level),
      .mem_gnt(mem_gnt), .col_detect(col_detect), .mac_tx_done(mac_tx_done),
      .remaining(remaining), .rem_zero(rem_zero), .at_limit(at_limit),
      .ag_load(ag_load), .ag_reload(ag_reload), .ag_step(ag_step),
      .rt_clear(rt_clear), .rt_hit(rt_hit),
      .mem_req(mem_req), .beat(beat), .flush(fifo_flush),
      .busy(busy), .done(done), .abort(xcol_abort), .rx_mode(rx_mode)
   );

   assign mem_rd     = beat && !rx_mode;
   assign mem_wr     = beat && rx_mode;
   assign fifo_push  = beat && !rx_mode;
   assign fifo_pop   = beat && rx_mode;
   assign fifo_wdata = mem_rdata;
   assign mem_wdata  = fifo_rdata;

endmodule

// File: rtl/ldma_engine_chk.sv
module ldma_engine_chk #(
   parameter int AW    = 16,
   parameter int BURST = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_rx,
   input logic          busy,
   input logic          done,
   input logic          xcol_abort,
   input logic          col_detect,
   input logic          fifo_flush,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] ring_start,
   input logic [AW-1:0] ring_end
);

   localparam int RW = $clog2(BURST + 2);

   logic          strb;
   logic [RW-1:0] run_q;
   logic          tx_lat;

   assign strb = mem_rd || mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         tx_lat <= 1'b0;
      end else begin
         run_q <= strb ? ((run_q == RW'(BURST + 1)) ? run_q : run_q + 1'b1) : '0;
         if (cmd_valid && !busy) tx_lat <= !cmd_rx;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !mem_rd && !mem_wr));

   p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_ring_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && $past(mem_wr) && ($past(mem_addr) == ring_end)) |-> (mem_addr == ring_start));

   p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> (run_q < RW'(BURST)));

   p_strobe_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> mem_req);

   p_grant_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !$past(strb)) |-> $past(mem_gnt));

   p_col_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (col_detect && busy && tx_lat) |=> fifo_flush);

   p_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && xcol_abort));

endmodule

bind ldma_engine ldma_engine_chk #(.AW(AW), .BURST(BURST)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rx(cmd_rx),
   .busy(busy), .done(done), .xcol_abort(xcol_abort), .col_detect(col_detect),
   .fifo_flush(fifo_flush), .mem_req(mem_req), .mem_gnt(mem_gnt),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
   .ring_start(ring_start), .ring_end(ring_end)
);

// File: tb/tb_ldma_engine.sv
`timescale 1ns/1ps
module tb_ldma_engine;
   localparam int AW = 8, LW = 6, DW = 8, FD = 8, BU = 4, LVW = 4;
   localparam logic [7:0] RLO = 8'h40, RHI = 8'h47;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 0, cmd_rx = 0, col_detect = 0, mac_tx_done = 0, mem_gnt = 0;
   logic [AW-1:0] cmd_addr = '0, ring_start = RLO, ring_end = RHI;
   logic [LW-1:0] cmd_len = '0;
   logic [LVW-1:0] fifo_free, fifo_level;
   logic [DW-1:0] fifo_rdata, fifo_wdata, mem_rdata, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic busy, done, xcol_abort, fifo_push, fifo_pop, fifo_flush, mem_req, mem_rd, mem_wr;

   always #10 clk = ~clk;

   ldma_engine #(.AW(AW), .LW(LW), .DW(DW), .FIFO_DEPTH(FD), .BURST(BU)) dut (.*);

   function automatic logic [7:0] fmem(input logic [7:0] a);
      return a * 8'd7 + 8'd3;
   endfunction
   function automatic logic [7:0] grx(input int i);
      return 8'(i * 13 + 5);
   endfunction

   int checks = 0, fails = 0, cyc = 0;
   int nlog = 0, tx_cnt = 0, pop_idx = 0, rx_avail = 0, cur_len = 0;
   bit cur_rx = 0, drain_en = 1, req_prev = 0;
   int gnt_delay = 0, gwait = 0, run = 0, free_prev = FD, lvl_prev = 0;
   int done_cnt = 0, abort_cnt = 0, flush_cnt = 0;
   int viol_thr = 0, viol_burst = 0, viol_req = 0, viol_ring = 0;
   logic [7:0] txlog [0:63];
   logic [7:0] rxmem [0:255];

   assign mem_rdata  = fmem(mem_addr);
   assign fifo_rdata = grx(pop_idx);
   assign fifo_free  = LVW'(FD - tx_cnt);
   assign fifo_level = LVW'(((rx_avail - pop_idx) > FD) ? FD : (rx_avail - pop_idx));

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // bench models: FIFO, bus arbiter, protocol monitor
   always @(negedge clk) begin
      int need, room, rem;
      cyc++;
      if (cyc > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
      end
      if (rst_n) begin
         if (mem_req && !req_prev) begin
            rem  = cur_len - (cur_rx ? pop_idx : nlog);
            need = (rem < BU) ? rem : BU;
            room = cur_rx ? lvl_prev : free_prev;
            if (room < need) viol_thr++;
         end
         if ((mem_rd || mem_wr) && !mem_req) viol_req++;
         run = (mem_rd || mem_wr) ? run + 1 : 0;
         if (run > BU) viol_burst++;
         if (done) done_cnt++;
         if (xcol_abort) abort_cnt++;
         if (drain_en && tx_cnt > 0) tx_cnt--;
         if (fifo_flush) begin flush_cnt++; tx_cnt = 0; nlog = 0; end
         if (fifo_push) begin txlog[nlog] = fifo_wdata; nlog++; tx_cnt++; end
         if (mem_wr) begin
            if (mem_addr < RLO || mem_addr > RHI) viol_ring++;
            rxmem[mem_addr] = mem_wdata;
            pop_idx++;
         end
         if (mem_req) begin
            if (gwait >= gnt_delay) mem_gnt = 1'b1; else gwait++;
         end else begin
            gwait = 0; mem_gnt = 1'b0;
         end
         req_prev  = mem_req;
         free_prev = FD - tx_cnt;
         lvl_prev  = ((rx_avail - pop_idx) > FD) ? FD : (rx_avail - pop_idx);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic start(input bit rx, input logic [7:0] a, input int len);
      nlog = 0; tx_cnt = 0; pop_idx = 0; cur_rx = rx; cur_len = len;
      done_cnt = 0; abort_cnt = 0; flush_cnt = 0;
      cmd_valid = 1; cmd_rx = rx; cmd_addr = a; cmd_len = LW'(len);
      tick(1);
      cmd_valid = 0;
   endtask

   task automatic wait_nlog(input int n, input string tag);
      int t = 0;
      while (nlog < n && t < 3000) begin tick(1); t++; end
      if (t >= 3000) chk(0, tag, nlog, n);
   endtask

   task automatic wait_end(input string tag);
      int t = 0;
      while (done_cnt + abort_cnt == 0 && t < 3000) begin tick(1); t++; end
      if (t >= 3000) chk(0, tag, 0, 1);
   endtask

   task automatic pulse_mac();
      mac_tx_done = 1; tick(1); mac_tx_done = 0;
   endtask

   task automatic pulse_col();
      col_detect = 1; tick(1); col_detect = 0;
   endtask

   task automatic check_txdata(input logic [7:0] a, input int len, input string tag);
      int errs = 0, first = -1;
      for (int i = 0; i < len; i++)
         if (txlog[i] !== fmem(8'(a + i))) begin errs++; if (first < 0) first = i; end
      chk(errs == 0 && nlog == len, tag, nlog, len);
   endtask

   task automatic tx_run(input logic [7:0] a, input int len, input int gd);
      gnt_delay = gd; drain_en = 1;
      start(0, a, len);
      wait_nlog(len, "R2 fetch timeout");
      tick(3);
      chk(done_cnt == 0 && busy, "R8 no done before mac_tx_done", done_cnt, 0);
      pulse_mac();
      tick(2);
      chk(done_cnt == 1 && !busy, "R8 done after mac_tx_done", done_cnt, 1);
      check_txdata(a, len, "R2 tx bytes/addresses");
   endtask

   task automatic rx_run(input logic [7:0] a, input int len);
      int errs = 0, lo;
      rx_avail = len;
      start(1, a, len);
      wait_end("R9 rx completion timeout");
      tick(1);
      chk(done_cnt == 1 && !busy, "R9 rx done", done_cnt, 1);
      chk(pop_idx == len, "R3 rx byte count", pop_idx, len);
      lo = (len > 8) ? len - 8 : 0;
      for (int i = lo; i < len; i++)
         if (rxmem[8'(RLO + ((a - RLO + i) % 8))] !== grx(i)) errs++;
      chk(errs == 0, "R3 rx ring placement", errs, 0);
   endtask

   initial begin
      tick(5);
      chk(!busy && !done && !xcol_abort && !mem_req && !mem_rd && !mem_wr, "R1 reset outputs", busy, 0);
      chk(!fifo_push && !fifo_pop && !fifo_flush, "R1 reset fifo strobes", fifo_push, 0);
      rst_n = 1;
      tick(2);
      chk(!busy && !mem_req, "R1 idle after reset", mem_req, 0);

      // transmit sweep: lengths around the burst size, several grant delays
      for (int gd = 0; gd < 3; gd++)
         for (int len = 1; len <= 9; len++)
            tx_run(8'(8'hF8 + len * 3), len, gd);
      gnt_delay = 1;

      // receive sweep: every start offset in the ring, lengths up to 10
      for (int off = 0; off < 8; off++)
         for (int len = 1; len <= 10; len += 3)
            rx_run(8'(RLO + off), len);

      // R4: transmit stalls on a full FIFO; R8: early mac_tx_done ignored
      drain_en = 0;
      start(0, 8'h30, 12);
      tick(40);
      chk(nlog == FD, "R4 tx fill stops at FIFO depth", nlog, FD);
      chk(!mem_req, "R4 no request while FIFO full", mem_req, 0);
      pulse_mac();
      tick(2);
      chk(done_cnt == 0 && busy, "R8 early mac_tx_done ignored", done_cnt, 0);
      drain_en = 1;
      wait_nlog(12, "R4 tx resume timeout");
      tick(2);
      pulse_mac();
      tick(2);
      chk(done_cnt == 1, "R8 done after stall", done_cnt, 1);
      check_txdata(8'h30, 12, "R2 tx bytes after stall");

      // R4: receive waits for a full burst in the FIFO
      rx_avail = 2;
      start(1, 8'h44, 8);
      rx_avail = 2;
      tick(20);
      chk(pop_idx == 0 && !mem_req, "R4 rx waits below threshold", pop_idx, 0);
      rx_avail = 8;
      wait_end("R9 rx after starve timeout");
      tick(1);
      chk(done_cnt == 1 && pop_idx == 8, "R9 rx done after starve", pop_idx, 8);

      // R6: collision in mid-fetch
      start(0, 8'h90, 9);
      wait_nlog(5, "R6 pre-collision fetch");
      pulse_col();
      tick(2);
      chk(flush_cnt == 1, "R6 flush after collision", flush_cnt, 1);
      wait_nlog(9, "R6 refetch timeout");
      tick(2);
      pulse_mac();
      tick(2);
      chk(done_cnt == 1 && abort_cnt == 0, "R6 done after retry", done_cnt, 1);
      check_txdata(8'h90, 9, "R6 refetch from start address");

      // R7: fifteen collisions retry, then completion
      start(0, 8'hC0, 3);
      for (int k = 0; k < 15; k++) begin
         wait_nlog(3, "R7 retry fetch");
         tick(1);
         pulse_col();
         tick(2);
      end
      chk(abort_cnt == 0 && busy && flush_cnt == 15, "R7 fifteen collisions retried", flush_cnt, 15);
      wait_nlog(3, "R7 final fetch");
      tick(1);
      pulse_mac();
      tick(2);
      chk(done_cnt == 1 && abort_cnt == 0, "R7 done after 15 retries", done_cnt, 1);
      check_txdata(8'hC0, 3, "R7 bytes after 15 retries");

      // R7: sixteenth collision aborts
      start(0, 8'hD0, 3);
      for (int k = 0; k < 16; k++) begin
         wait_nlog(3, "R7 abort fetch");
         tick(1);
         pulse_col();
         tick(2);
      end
      chk(abort_cnt == 1 && done_cnt == 0 && !busy, "R7 abort on 16th collision", abort_cnt, 1);
      chk(flush_cnt == 16, "R7 flush count with abort", flush_cnt, 16);
      pulse_mac();
      tick(2);
      chk(done_cnt == 0, "R8 mac_tx_done after abort ignored", done_cnt, 0);

      // R10: command while busy is ignored
      start(0, 8'h10, 8);
      wait_nlog(2, "R10 first bytes");
      cmd_valid = 1; cmd_rx = 1; cmd_addr = 8'h80; cmd_len = 6'd3;
      tick(1);
      cmd_valid = 0;
      wait_nlog(8, "R10 fetch timeout");
      tick(2);
      pulse_mac();
      tick(2);
      chk(done_cnt == 1 && pop_idx == 0, "R10 second command ignored", pop_idx, 0);
      check_txdata(8'h10, 8, "R10 original packet intact");

      chk(viol_thr == 0, "R4 threshold before every request", viol_thr, 0);
      chk(viol_burst == 0, "R4 burst length bound", viol_burst, 0);
      chk(viol_req == 0, "R5 strobe only under request", viol_req, 0);
      chk(viol_ring == 0, "R3 writes stay inside ring", viol_ring, 0);
      summary();
   end
endmodule